// File: doc/BRIEF.md
# Host Command Issue Sequencer

This block runs a single command through the byte-wide register window of a storage host adapter. A start pulse captures an opcode, up to five parameter bytes with their count, and the number of reply bytes expected (up to 256). The sequencer then works through the adapter's registers with single read or write transactions. It waits for the adapter to report ready, sends the opcode and parameters, and collects the reply bytes into an external buffer through a write strobe. It then waits for the command-complete interrupt flag, checks the status register and acknowledges the interrupt.

Every wait works by polling, and each poll is one read transaction. If an iteration of a transfer loop finds command-complete already set, the loop ends early. A wait that makes no progress for `POLL_LIMIT` consecutive polls ends the command as a failure. When the command ends, a single-cycle `done` pulse reports a success flag and the number of reply bytes that were actually stored.

The register window is decoded at three offsets. Offset 0 is status when read and control when written. Offset 1 takes command and parameter bytes when written and gives reply data when read. Offset 2 is the interrupt flag register, which is read only.

Top module: `hci_issuer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `io_req` and `reply_we` are all 0.
- R2: Before the opcode is written, the block reads offset 0 repeatedly until a read returns bit 4 (0x10, adapter ready) set. For opcodes 0x02 and 0x05 this wait is skipped and the opcode is written first.
- R3: The opcode is written to offset 1 with no busy check. Each parameter byte goes to offset 1, lowest byte of `params` first, and only after a read of offset 0 has returned bit 3 (0x08, busy) clear. Exactly `param_cnt` bytes are written (0 to 5) unless the loop is ended early.
- R4: A reply byte is read from offset 1 only after a read of offset 0 has returned bit 2 (0x04, data ready) set. Each reply byte is presented on `reply_we`/`reply_idx`/`reply_data`, with indices counting up from 0.
- R5: Each iteration of the parameter loop and of the reply loop ends with one read of offset 2. If that read has bit 2 (0x04, command complete) set, no further parameter or reply transfers take place.
- R6: After the transfer phases, the block reads offset 2 until bit 2 is set, then reads offset 0 once, then writes 0x20 to offset 0 once. Every write to offset 0 carries 0x20.
- R7: `done` is a single-cycle pulse. `ok` is 0 when the final status read had bit 0 (0x01, command invalid) set, and 1 otherwise.
- R8: In any wait, `POLL_LIMIT` consecutive polls without progress end the command with `done` and `ok`=0. In that case no control write is made.
- R9: At `done`, `rx_count` equals the number of reply bytes that were stored.
- R10: A `start` pulse that arrives while `busy` is 1 has no effect on the running command and does not begin a new one.
- R11: Once `io_req` is raised, it stays high with `io_wr`, `io_addr` and `io_wdata` unchanged until the cycle in which `io_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (ignored while busy) |
| opcode | input | 8 | Command opcode |
| params | input | MAX_PARAMS*8 | Parameter bytes, byte 0 in bits 7:0 |
| param_cnt | input | clog2(MAX_PARAMS+1) | Number of parameter bytes |
| reply_len | input | clog2(MAX_REPLY+1) | Expected reply byte count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success flag, valid with done |
| rx_count | output | clog2(MAX_REPLY+1) | Reply bytes stored, valid with done |
| io_req | output | 1 | Register transaction request |
| io_wr | output | 1 | 1 = write, 0 = read |
| io_addr | output | 2 | Register offset |
| io_wdata | output | 8 | Write data |
| io_rdata | input | 8 | Read data, valid with io_ack |
| io_ack | input | 1 | Transaction complete |
| reply_we | output | 1 | Reply byte strobe |
| reply_idx | output | clog2(MAX_REPLY) | Reply byte index |
| reply_data | output | 8 | Reply byte value |

## Verification
Each acknowledged transaction moves the sequencer on at that clock edge. The next request is presented in the same cycle, so a reply strobe appears one cycle after the data read's acknowledge, and `done` appears one cycle after the acknowledge of the control write or of the poll that expired. The bench acknowledges with a random latency of 0 to 2 cycles. It samples every output on the falling edge, logging each strobe and each `done` pulse as it happens, so no result depends on an exact cycle count. Expected transaction counts, logged bytes, `ok` and `rx_count` are computed from the command and from the adapter model's scenario settings.

// File: rtl/hci_pkg.sv
package hci_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RDY,
        S_OPC,
        S_PSTAT,
        S_PWR,
        S_PIRQ,
        S_RSTAT,
        S_RRD,
        S_RIRQ,
        S_FIRQ,
        S_FSTAT,
        S_CLR
    } hci_state_e;

    localparam logic [1:0] A_STATCTL = 2'd0;
    localparam logic [1:0] A_CMDDATA = 2'd1;
    localparam logic [1:0] A_IRQ     = 2'd2;

    localparam int ST_READY_BIT = 4;
    localparam int ST_BUSY_BIT  = 3;
    localparam int ST_DIN_BIT   = 2;
    localparam int ST_INV_BIT   = 0;
    localparam int IR_DONE_BIT  = 2;

    localparam logic [7:0] CTL_IRQ_ACK = 8'h20;
    localparam logic [7:0] OPC_NOWAIT0 = 8'h02;
    localparam logic [7:0] OPC_NOWAIT1 = 8'h05;

endpackage

// File: rtl/hci_poll_timer.sv
module hci_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic at_limit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = at_limit ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q == CW'(LIMIT - 1));

    // R8: the count of consecutive unproductive polls never passes the limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < LIMIT);

endmodule

// File: rtl/hci_param_sel.sv
module hci_param_sel #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N*8-1:0] bytes_i,
    input  logic [IW-1:0]  sel_i,
    output logic [7:0]     byte_o
);
    logic [7:0] lane [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_lane
        assign lane[gi] = bytes_i[gi*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < N; i++) begin
            if (sel_i == IW'(i)) byte_o = lane[i];
        end
    end

endmodule

// File: rtl/hci_issuer.sv
module hci_issuer
    import hci_pkg::*;
#(
    parameter int MAX_PARAMS = 5,
    parameter int MAX_REPLY  = 256,
    parameter int POLL_LIMIT = 1000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [7:0]                            opcode,
    input  logic [MAX_PARAMS*8-1:0]               params,
    input  logic [$clog2(MAX_PARAMS+1)-1:0]       param_cnt,
    input  logic [$clog2(MAX_REPLY+1)-1:0]        reply_len,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  ok,
    output logic [$clog2(MAX_REPLY+1)-1:0]        rx_count,
    output logic                                  io_req,
    output logic                                  io_wr,
    output logic [1:0]                            io_addr,
    output logic [7:0]                            io_wdata,
    input  logic [7:0]                            io_rdata,
    input  logic                                  io_ack,
    output logic                                  reply_we,
    output logic [$clog2(MAX_REPLY)-1:0]          reply_idx,
    output logic [7:0]                            reply_data
);
    localparam int PCW = $clog2(MAX_PARAMS + 1);
    localparam int RLW = $clog2(MAX_REPLY + 1);
    localparam int RIW = $clog2(MAX_REPLY);

    typedef struct packed {
        hci_state_e              state;
        logic [7:0]              opc;
        logic [MAX_PARAMS*8-1:0] prm;
        logic [PCW-1:0]          pcnt;
        logic [RLW-1:0]          rlen;
        logic [PCW-1:0]          sent;
        logic [RLW-1:0]          got;
        logic                    inv;
        logic                    done;
        logic                    ok;
        logic                    rwe;
        logic [RIW-1:0]          ridx;
        logic [7:0]              rdat;
    } regs_t;

    regs_t r_d, r_q;

    logic       poll_tick, poll_clr, poll_at_limit;
    logic [7:0] cur_param;
    logic [PCW-1:0] pcnt_in;
    logic [RLW-1:0] rlen_in;

    hci_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .tick     (poll_tick),
        .at_limit (poll_at_limit)
    );

    hci_param_sel #(.N(MAX_PARAMS), .IW(PCW)) u_sel (
        .bytes_i (r_q.prm),
        .sel_i   (r_q.sent),
        .byte_o  (cur_param)
    );

    assign pcnt_in = (int'(param_cnt) > MAX_PARAMS) ? PCW'(MAX_PARAMS) : param_cnt;
    assign rlen_in = (int'(reply_len) > MAX_REPLY)  ? RLW'(MAX_REPLY)  : reply_len;

    // next state
    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.rwe   = 1'b0;
        poll_tick = 1'b0;
        poll_clr  = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.opc  = opcode;
                    r_d.prm  = params;
                    r_d.pcnt = pcnt_in;
                    r_d.rlen = rlen_in;
                    r_d.sent = '0;
                    r_d.got  = '0;
                    r_d.inv  = 1'b0;
                    poll_clr = 1'b1;
                    r_d.state = (opcode == OPC_NOWAIT0 || opcode == OPC_NOWAIT1)
                                ? S_OPC : S_RDY;
                end
            end
            S_RDY: if (io_ack) begin
                if (io_rdata[ST_READY_BIT]) begin
                    poll_clr  = 1'b1;
                    r_d.state = S_OPC;
                end else begin
                    poll_tick = 1'b1;
                end
            end
            S_OPC: if (io_ack) begin
                poll_clr = 1'b1;
                if (r_q.pcnt != '0)      r_d.state = S_PSTAT;
                else if (r_q.rlen != '0) r_d.state = S_RSTAT;
                else                     r_d.state = S_FIRQ;
            end
            S_PSTAT: if (io_ack) begin
                if (!io_rdata[ST_BUSY_BIT]) begin
                    r_d.state = S_PWR;
                end else begin
                    poll_tick = 1'b1;
                    r_d.state = S_PIRQ;
                end
            end
            S_PWR: if (io_ack) begin
                poll_clr  = 1'b1;
                r_d.sent  = r_q.sent + PCW'(1);
                r_d.state = S_PIRQ;
            end
            S_PIRQ: if (io_ack) begin
                if (io_rdata[IR_DONE_BIT]) begin
                    poll_clr  = 1'b1;
                    r_d.state = S_FIRQ;
                end else if (r_q.sent == r_q.pcnt) begin
                    poll_clr  = 1'b1;
                    r_d.state = (r_q.rlen != '0) ? S_RSTAT : S_FIRQ;
                end else begin
                    r_d.state = S_PSTAT;
                end
            end
            S_RSTAT: if (io_ack) begin
                if (io_rdata[ST_DIN_BIT]) begin
                    r_d.state = S_RRD;
                end else begin
                    poll_tick = 1'b1;
                    r_d.state = S_RIRQ;
                end
            end
            S_RRD: if (io_ack) begin
                poll_clr  = 1'b1;
                r_d.rwe   = 1'b1;
                r_d.ridx  = r_q.got[RIW-1:0];
                r_d.rdat  = io_rdata;
                r_d.got   = r_q.got + RLW'(1);
                r_d.state = S_RIRQ;
            end
            S_RIRQ: if (io_ack) begin
                if (io_rdata[IR_DONE_BIT] || r_q.got == r_q.rlen) begin
                    poll_clr  = 1'b1;
                    r_d.state = S_FIRQ;
                end else begin
                    r_d.state = S_RSTAT;
                end
            end
            S_FIRQ: if (io_ack) begin
                if (io_rdata[IR_DONE_BIT]) begin
                    poll_clr  = 1'b1;
                    r_d.state = S_FSTAT;
                end else begin
                    poll_tick = 1'b1;
                end
            end
            S_FSTAT: if (io_ack) begin
                r_d.inv   = io_rdata[ST_INV_BIT];
                r_d.state = S_CLR;
            end
            S_CLR: if (io_ack) begin
                r_d.done  = 1'b1;
                r_d.ok    = !r_q.inv;
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase

        if (poll_tick && poll_at_limit) begin
            r_d.done  = 1'b1;
            r_d.ok    = 1'b0;
            r_d.state = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // register window drive
    always_comb begin
        io_req   = 1'b1;
        io_wr    = 1'b0;
        io_addr  = A_STATCTL;
        io_wdata = 8'h00;
        case (r_q.state)
            S_IDLE:  io_req = 1'b0;
            S_OPC:   begin io_wr = 1'b1; io_addr = A_CMDDATA; io_wdata = r_q.opc;   end
            S_PWR:   begin io_wr = 1'b1; io_addr = A_CMDDATA; io_wdata = cur_param; end
            S_RRD:   io_addr = A_CMDDATA;
            S_PIRQ, S_RIRQ, S_FIRQ: io_addr = A_IRQ;
            S_CLR:   begin io_wr = 1'b1; io_addr = A_STATCTL; io_wdata = CTL_IRQ_ACK; end
            default: io_addr = A_STATCTL;
        endcase
    end

    assign busy       = (r_q.state != S_IDLE);
    assign done       = r_q.done;
    assign ok         = r_q.ok;
    assign rx_count   = r_q.got;
    assign reply_we   = r_q.rwe;
    assign reply_idx  = r_q.ridx;
    assign reply_data = r_q.rdat;

    // R11: a pending request holds its address, direction and data until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_wr) && $stable(io_wdata));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the only value ever written to the control register is the interrupt acknowledge
    a_r6_ctl_value: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_wr && io_addr == A_STATCTL |-> io_wdata == CTL_IRQ_ACK);

    // R9: the stored reply count never exceeds the requested length
    a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rx_count <= r_q.rlen);

    // R4: reply strobes stay inside the requested length
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        reply_we |-> RLW'(reply_idx) < r_q.rlen);

    // R3: no parameter write beyond the requested count
    a_r3_param_bound: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && io_wr && io_addr == A_CMDDATA && r_q.state == S_PWR |-> r_q.sent < r_q.pcnt);

    // R10: a start during a command leaves the captured opcode alone
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(r_q.opc) && $stable(r_q.pcnt));

endmodule

// File: tb/hci_issuer_bench.sv
`timescale 1ns/1ps
module hci_issuer_bench;
    localparam int NP    = 5;
    localparam int NR    = 256;
    localparam int LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [NP*8-1:0] params = '0;
    logic [2:0]  param_cnt = '0;
    logic [8:0]  reply_len = '0;
    logic        busy, done, ok;
    logic [8:0]  rx_count;
    logic        io_req, io_wr;
    logic [1:0]  io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata = 8'h00;
    logic        io_ack = 1'b0;
    logic        reply_we;
    logic [7:0]  reply_idx, reply_data;

    hci_issuer #(.MAX_PARAMS(NP), .MAX_REPLY(NR), .POLL_LIMIT(LIMIT)) u_hci_issuer (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .params(params),
        .param_cnt(param_cnt), .reply_len(reply_len), .busy(busy), .done(done), .ok(ok),
        .rx_count(rx_count), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack), .reply_we(reply_we),
        .reply_idx(reply_idx), .reply_data(reply_data)
    );

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    bit finished = 0;

    // adapter model scenario
    int m_ready_after, m_avail, m_wr_target, m_seed;
    bit m_hang, m_invalid;
    int m_wr_cnt, m_rd_cnt, m_clr_cnt, m_pre_reads, m_stat_reads, m_hold_err;
    logic [7:0] m_clr_val;
    logic [7:0] m_wlog [0:15];
    logic [7:0] cap [0:NR-1];
    int cap_cnt, cap_bad, done_cnt;
    logic last_ok;
    logic [8:0] last_rx;

    function automatic logic [7:0] rbyte(int k, int s);
        return 8'((k * 29 + s * 7 + 3) & 255);
    endfunction

    function automatic bit cc_now();
        return !m_hang && m_wr_cnt >= m_wr_target && m_rd_cnt >= m_avail;
    endfunction

    task automatic chk(bit cond, string tag, int act, int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // adapter register model
    initial begin
        int dly;
        logic [1:0] h_addr;
        logic h_wr;
        logic [7:0] h_wdata;
        bit holding;
        dly = 0;
        holding = 0;
        h_addr = '0; h_wr = 0; h_wdata = '0;
        forever begin
            @(negedge clk);
            if (io_ack) begin
                io_ack = 1'b0;
                dly = $urandom % 3;
                holding = 0;
            end else if (io_req) begin
                if (holding && (h_addr != io_addr || h_wr != io_wr || h_wdata != io_wdata))
                    m_hold_err++;
                holding = 1; h_addr = io_addr; h_wr = io_wr; h_wdata = io_wdata;
                if (dly > 0) begin
                    dly--;
                end else begin
                    if (io_wr) begin
                        if (io_addr == 2'd1) begin
                            if (m_wr_cnt < 16) m_wlog[m_wr_cnt] = io_wdata;
                            m_wr_cnt++;
                        end else if (io_addr == 2'd0) begin
                            m_clr_cnt++;
                            m_clr_val = io_wdata;
                        end
                    end else begin
                        case (io_addr)
                            2'd0: begin
                                io_rdata = 8'h00;
                                if (m_stat_reads >= m_ready_after) io_rdata[4] = 1'b1;
                                if ($urandom % 3 == 0) io_rdata[3] = 1'b1;
                                if (m_wr_cnt >= m_wr_target && m_rd_cnt < m_avail && ($urandom % 3 != 0))
                                    io_rdata[2] = 1'b1;
                                if (m_invalid && cc_now()) io_rdata[0] = 1'b1;
                                if (m_wr_cnt == 0) m_pre_reads++;
                                m_stat_reads++;
                            end
                            2'd1: begin
                                io_rdata = rbyte(m_rd_cnt, m_seed);
                                m_rd_cnt++;
                            end
                            default: io_rdata = cc_now() ? 8'h84 : 8'h80;
                        endcase
                    end
                    io_ack = 1'b1;
                end
            end
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (reply_we) begin
                if (rx_count > 9'd256) cap_bad++;
                cap[reply_idx] = reply_data;
                cap_cnt++;
            end
            if (done) begin
                done_cnt++;
                last_ok = ok;
                last_rx = rx_count;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_cmd(input logic [7:0] opc, input int cnt, input int len,
                           input int ready_after, input int avail_req, input int abort_w,
                           input bit invalid, input bit hang, input bit poke);
        logic [NP*8-1:0] pv;
        bit skip, rdy_to;
        int exp_rx, exp_wr, exp_pre, exp_clr, dc0, ccnt0;
        bit exp_ok, wl_ok, cap_ok;
        for (int i = 0; i < NP; i++) pv[i*8 +: 8] = 8'($urandom);
        skip = (opc == 8'h02 || opc == 8'h05);
        rdy_to = !skip && ready_after >= LIMIT;
        m_ready_after = ready_after;
        m_wr_target = (abort_w >= 2 && abort_w < 1 + cnt) ? abort_w : 1 + cnt;
        m_avail = (m_wr_target < 1 + cnt) ? 0 : ((avail_req < len) ? avail_req : len);
        m_invalid = invalid; m_hang = hang; m_seed = int'($urandom % 200);
        m_wr_cnt = 0; m_rd_cnt = 0; m_clr_cnt = 0; m_pre_reads = 0; m_stat_reads = 0;
        m_clr_val = 8'h00;
        cap_cnt = 0;
        dc0 = done_cnt;
        @(negedge clk);
        opcode = opc; params = pv; param_cnt = 3'(cnt); reply_len = 9'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            opcode = 8'hEE; param_cnt = 3'd0; reply_len = 9'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == dc0) @(negedge clk);
        ccnt0 = cap_cnt;
        repeat (6) @(negedge clk);

        exp_wr  = rdy_to ? 0 : m_wr_target;
        exp_rx  = rdy_to ? 0 : m_avail;
        exp_ok  = !rdy_to && !hang && !invalid;
        exp_clr = (rdy_to || hang) ? 0 : 1;
        exp_pre = skip ? 0 : (rdy_to ? LIMIT : ready_after + 1);

        chk(last_ok == exp_ok, "R7 ok flag", int'(last_ok), int'(exp_ok));
        chk(done_cnt == dc0 + 1, "R7/R10 single done", done_cnt - dc0, 1);
        chk(int'(last_rx) == exp_rx, "R9 rx_count", int'(last_rx), exp_rx);
        chk(cap_cnt == exp_rx && ccnt0 == cap_cnt, "R4 reply strobes", cap_cnt, exp_rx);
        cap_ok = 1;
        for (int k = 0; k < exp_rx; k++) if (cap[k] !== rbyte(k, m_seed)) cap_ok = 0;
        chk(cap_ok, "R4 reply data", int'(cap_ok), 1);
        chk(m_rd_cnt == exp_rx, "R5 data reads", m_rd_cnt, exp_rx);
        chk(m_wr_cnt == exp_wr, "R3/R5 byte writes", m_wr_cnt, exp_wr);
        wl_ok = 1;
        if (exp_wr > 0 && m_wlog[0] !== opc) wl_ok = 0;
        for (int i = 1; i < exp_wr; i++) if (m_wlog[i] !== pv[(i-1)*8 +: 8]) wl_ok = 0;
        chk(wl_ok, "R3 opcode and parameter bytes", int'(wl_ok), 1);
        chk(m_pre_reads == exp_pre, rdy_to ? "R8 ready timeout polls" : "R2 ready wait reads",
            m_pre_reads, exp_pre);
        chk(m_clr_cnt == exp_clr, hang ? "R8 no clear on timeout" : "R6 clear writes",
            m_clr_cnt, exp_clr);
        if (exp_clr == 1) chk(m_clr_val == 8'h20, "R6 clear value", int'(m_clr_val), 32);
        chk(m_hold_err == 0, "R11 request held", m_hold_err, 0);
        if (poke) chk(io_req == 1'b0 && busy == 1'b0, "R10 no second command",
                      int'(io_req), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_hold_err = 0; done_cnt = 0; cap_bad = 0;
        m_wr_target = 1; m_avail = 0; m_hang = 0; m_invalid = 0; m_ready_after = 0;
        m_wr_cnt = 0; m_rd_cnt = 0; m_stat_reads = 0; m_seed = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !io_req && !reply_we, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !io_req, "R1 idle after reset", int'(io_req), 0);

        // directed corners
        run_cmd(8'h04, 0, 4, 2, 4, 0, 0, 0, 0);      // plain inquiry
        run_cmd(8'h02, 0, 0, 5, 0, 0, 0, 0, 0);      // R2 skip opcode
        run_cmd(8'h05, 1, 0, 5, 0, 0, 0, 0, 0);      // R2 skip opcode
        run_cmd(8'h8D, 1, 256, 0, 256, 0, 0, 0, 0);  // full reply buffer
        run_cmd(8'h01, 4, 0, 1, 0, 3, 0, 0, 0);      // R5 abort in parameters
        run_cmd(8'h0B, 0, 10, 0, 3, 0, 0, 0, 0);     // R5 abort in reply
        run_cmd(8'h0B, 0, 3, 0, 0, 0, 0, 0, 0);      // R5 abort before any reply
        run_cmd(8'h33, 2, 2, 0, 2, 0, 1, 0, 0);      // R7 invalid
        run_cmd(8'h11, 0, 0, 1000, 0, 0, 0, 0, 0);   // R8 ready wait timeout
        run_cmd(8'h12, 2, 3, 1, 3, 0, 0, 1, 0);      // R8 completion never set
        run_cmd(8'h29, 2, 0, 0, 0, 0, 0, 0, 1);      // R10 start while busy
        run_cmd(8'h06, 5, 5, 3, 5, 0, 0, 0, 1);      // R10 start while busy

        // constrained random
        for (int t = 0; t < 30; t++) begin
            logic [7:0] o;
            int c, l, av, ab;
            o  = (t % 7 == 0) ? 8'h02 : ((t % 7 == 3) ? 8'h05 : 8'($urandom));
            c  = int'($urandom % 6);
            l  = int'($urandom % 24);
            av = ($urandom % 4 == 0) ? int'($urandom % (l + 1)) : l;
            ab = ($urandom % 5 == 0) ? 2 + int'($urandom % 4) : 0;
            run_cmd(o, c, l, int'($urandom % 4), av, ab, ($urandom % 4 == 0), 0, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule